// File: doc/BRIEF.md
# Debug Command Register Access Engine

This block sits behind a host debug port and turns a stream of bytes into accesses to a small bank of debug registers. Each command opens with an 8-bit opcode. Depending on the opcode, zero, one or two data bytes follow. The bank holds these registers:

- an 8-bit control register;
- an 8-bit flags register that the host can only read;
- a 16-bit address register;
- a 16-bit data register;
- six 16-bit breakpoint registers.

A simple byte strobe stands in for the shift logic of the test access port.

For a read, the selected register is copied into a 16-bit staging buffer when the opcode arrives. The low byte of that buffer is always presented on `byte_out`. Each follow-on strobe moves the next byte into view, low byte first. For a write, the incoming bytes collect in the staging buffer, low byte first. The target register changes only on the final byte. A dedicated opcode asks the CPU to halt at its next instruction boundary. A request line is held until the CPU acknowledges, and then a debug-mode flag is recorded.

Top module: `dbg_cmd_engine`

## Requirements
- R1: A synchronous active-high reset clears every register, the staging buffer (`byte_out` = 0x00) and `halt_req`.
- R2: Undefined opcodes do nothing: no register changes, `byte_out` stays 0x00 and the next byte is again taken as an opcode. The undefined opcodes are every value other than 0x01–0x0A, 0x11, 0x13–0x1A and 0x1F, and they include 0x00 and 0x12.
- R3: Opcodes 0x01 (control) and 0x02 (flags) are 8-bit reads. After the opcode strobe, `byte_out` equals the register value. One follow-on strobe ends the command.
- R4: Opcodes 0x03 (address), 0x04 (data) and 0x05–0x0A (breakpoints 0–5) are 16-bit reads. After the opcode, `byte_out` shows bits 7:0. After the first follow-on strobe it shows bits 15:8, and a second follow-on strobe ends the command. The byte values the host sends during a read have no effect.
- R5: Opcodes 0x13 (address), 0x14 (data) and 0x15–0x1A (breakpoints 0–5) are 16-bit writes that take the low byte first. The register is updated only at the second data byte.
- R6: Opcode 0x11 writes the control register with exactly one data byte.
- R7: The breakpoint registers are independent. A write to one of them leaves the other registers unchanged.
- R8: Opcode 0x1F raises `halt_req`, which stays high until `cpu_halted` is seen. It then drops, and flags bit 0 (debug mode) becomes 1. Flags bit 1 reads 1 while a halt is pending. All other flags bits read 0.
- R9: After the last byte of any command, the block is back in its opcode-wait state and `byte_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in_valid | input | 1 | One-cycle strobe: a host byte is present |
| byte_in | input | 8 | Host byte (opcode or data) |
| byte_out | output | 8 | Byte the host reads next |
| halt_req | output | 1 | Halt request to the CPU |
| cpu_halted | input | 1 | CPU acknowledge that it has halted |

## Verification
If the sequencer kept a stale byte count, the next opcode would be taken as data. That error would show at once as a wrong `byte_out` on the following strobe, and again when the register is read back. A write committed too early, or to the wrong register, shows up at the read-back of the whole bank that follows each write sweep. A lost halt handshake shows within a cycle on `halt_req`, and on the next flags read.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_W    = 16;
    localparam int NUM_BP   = 6;
    localparam int SEL_W    = 4;

    // register selectors equal the low nibble of the opcode
    localparam logic [SEL_W-1:0] SEL_CTRL  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 4'd2;
    localparam logic [SEL_W-1:0] SEL_ADDR  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_DATA  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_BP0   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_LAST  = SEL_BP0 + SEL_W'(NUM_BP - 1);

    localparam logic [BYTE_W-1:0] OP_HALT  = 8'h1F;

    typedef enum logic [1:0] {ST_IDLE, ST_BYTE0, ST_BYTE1} seq_state_t;
    typedef enum logic [1:0] {K_NOP, K_READ, K_WRITE, K_HALT} cmd_kind_t;

    typedef struct packed {
        cmd_kind_t        kind;
        logic [SEL_W-1:0] sel;
        logic             wide;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_op(input logic [BYTE_W-1:0] op);
        cmd_dec_t         d;
        logic [SEL_W-1:0] s;
        logic             in_range;
        s        = op[SEL_W-1:0];
        in_range = (s >= SEL_CTRL) && (s <= SEL_LAST);
        d.kind   = K_NOP;
        d.sel    = s;
        d.wide   = (s >= SEL_ADDR);
        if (op == OP_HALT) begin
            d.kind = K_HALT;
        end else if (op[7:5] == 3'b000 && in_range) begin
            if (!op[4]) d.kind = K_READ;
            else if (s != SEL_FLAGS) d.kind = K_WRITE;
        end
        return d;
    endfunction

endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0] flags,
    output logic [REG_W-1:0]  rd_data
);

    logic [BYTE_W-1:0] ctrl_q;
    logic [REG_W-1:0]  addr_q;
    logic [REG_W-1:0]  data_q;
    logic [REG_W-1:0]  bp_q [NUM_BP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= wr_data[BYTE_W-1:0];
            if (wr_sel == SEL_ADDR) addr_q <= wr_data;
            if (wr_sel == SEL_DATA) data_q <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        localparam logic [SEL_W-1:0] MY_SEL = SEL_BP0 + SEL_W'(i);
        always_ff @(posedge clk) begin
            if (rst) bp_q[i] <= '0;
            else if (wr_en && wr_sel == MY_SEL) bp_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_CTRL)       rd_data = {{(REG_W-BYTE_W){1'b0}}, ctrl_q};
        else if (rd_sel == SEL_FLAGS) rd_data = {{(REG_W-BYTE_W){1'b0}}, flags};
        else if (rd_sel == SEL_ADDR)  rd_data = addr_q;
        else if (rd_sel == SEL_DATA)  rd_data = data_q;
        else begin
            for (int i = 0; i < NUM_BP; i++)
                if (rd_sel == SEL_BP0 + SEL_W'(i)) rd_data = bp_q[i];
        end
    end

    AST_NO_STRAY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(addr_q) && $stable(data_q) && $stable(ctrl_q))) // R5
        else $error("register changed without a commit");

endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_cmd,
    input  logic              cpu_halted,
    output logic              halt_req,
    output logic [BYTE_W-1:0] flags
);

    logic dbg_mode_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            dbg_mode_q <= 1'b0;
        end else if (pend_q && cpu_halted) begin
            pend_q     <= 1'b0;
            dbg_mode_q <= 1'b1;
        end else if (halt_cmd) begin
            pend_q     <= 1'b1;
        end
    end

    assign halt_req = pend_q;
    assign flags    = {{(BYTE_W-2){1'b0}}, pend_q, dbg_mode_q};

    AST_HALT_HELD: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !cpu_halted) |=> halt_req) // R8
        else $error("halt request dropped early");

    AST_HALT_ACKED: assert property (@(posedge clk) disable iff (rst)
        (halt_req && cpu_halted) |=> (!halt_req && flags[0])) // R8
        else $error("acknowledge not recorded");

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_in_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [REG_W-1:0]  rd_data,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [REG_W-1:0]  wr_data,
    output logic              halt_cmd,
    output logic [BYTE_W-1:0] byte_out
);

    seq_state_t       state_q;
    logic [REG_W-1:0] stage_q;
    logic [SEL_W-1:0] sel_q;
    logic             wide_q;
    logic             is_wr_q;
    cmd_dec_t         dec;
    logic             last_byte;

    assign dec       = decode_op(byte_in);
    assign rd_sel    = dec.sel;
    assign last_byte = (state_q == ST_BYTE1) || (state_q == ST_BYTE0 && !wide_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            sel_q   <= '0;
            wide_q  <= 1'b0;
            is_wr_q <= 1'b0;
        end else if (byte_in_valid) begin
            case (state_q)
                ST_IDLE: begin
                    sel_q  <= dec.sel;
                    wide_q <= dec.wide;
                    if (dec.kind == K_READ) begin
                        stage_q <= rd_data;
                        is_wr_q <= 1'b0;
                        state_q <= ST_BYTE0;
                    end else if (dec.kind == K_WRITE) begin
                        stage_q <= '0;
                        is_wr_q <= 1'b1;
                        state_q <= ST_BYTE0;
                    end
                end
                ST_BYTE0: begin
                    if (wide_q) begin
                        state_q <= ST_BYTE1;
                        if (is_wr_q) stage_q <= {{(REG_W-BYTE_W){1'b0}}, byte_in};
                        else         stage_q <= {{BYTE_W{1'b0}}, stage_q[REG_W-1:BYTE_W]};
                    end else begin
                        state_q <= ST_IDLE;
                        stage_q <= '0;
                    end
                end
                ST_BYTE1: begin
                    state_q <= ST_IDLE;
                    stage_q <= '0;
                end
                default: begin
                    state_q <= ST_IDLE;
                    stage_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        wr_en   = byte_in_valid && is_wr_q && last_byte;
        wr_sel  = sel_q;
        wr_data = (state_q == ST_BYTE1) ? {byte_in, stage_q[BYTE_W-1:0]}
                                        : {{(REG_W-BYTE_W){1'b0}}, byte_in};
    end

    assign halt_cmd = byte_in_valid && (state_q == ST_IDLE) && (dec.kind == K_HALT);
    assign byte_out = stage_q[BYTE_W-1:0];

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (byte_out == '0)) // R9
        else $error("buffer not cleared in idle");

    AST_NOP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && byte_in_valid && dec.kind == K_NOP)
            |=> (state_q == ST_IDLE)) // R2
        else $error("undefined opcode left idle");

    AST_COMMIT_LAST: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state_q != ST_IDLE)) // R5
        else $error("commit outside a data phase");

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_in_valid,
    input  logic [7:0]  byte_in,
    output logic [7:0]  byte_out,
    output logic        halt_req,
    input  logic        cpu_halted
);

    logic [SEL_W-1:0]  rd_sel;
    logic [SEL_W-1:0]  wr_sel;
    logic              wr_en;
    logic [REG_W-1:0]  wr_data;
    logic [REG_W-1:0]  rd_data;
    logic              halt_cmd;
    logic [BYTE_W-1:0] flags;

    dbg_cmd_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .byte_in_valid (byte_in_valid),
        .byte_in       (byte_in),
        .rd_data       (rd_data),
        .rd_sel        (rd_sel),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .halt_cmd      (halt_cmd),
        .byte_out      (byte_out)
    );

    dbg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_sel  (rd_sel),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .flags   (flags),
        .rd_data (rd_data)
    );

    dbg_halt_ctl u_halt (
        .clk        (clk),
        .rst        (rst),
        .halt_cmd   (halt_cmd),
        .cpu_halted (cpu_halted),
        .halt_req   (halt_req),
        .flags      (flags)
    );

endmodule

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_in_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] byte_out;
    logic       halt_req;
    logic       cpu_halted = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // model: index 1 ctrl, 3 addr, 4 data, 5..10 breakpoints
    logic [15:0] model [11];

    always #4 clk = ~clk;

    dbg_cmd_engine dut_i (
        .clk           (clk),
        .rst           (rst),
        .byte_in_valid (byte_in_valid),
        .byte_in       (byte_in),
        .byte_out      (byte_out),
        .halt_req      (halt_req),
        .cpu_halted    (cpu_halted)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_in_valid = 1'b1;
        byte_in       = b;
        @(negedge clk);
        byte_in_valid = 1'b0;
        byte_in       = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 11; i++) model[i] = 16'h0000;
    endtask

    task automatic read8(input logic [7:0] op, input logic [7:0] exp, input string req);
        send(op);
        check(req, {8'h00, byte_out}, {8'h00, exp});
        send(8'hFF);
        check("R9 idle after 8-bit read", {8'h00, byte_out}, 16'h0000);
    endtask

    task automatic read16(input logic [7:0] op, input logic [15:0] exp, input string req);
        logic [7:0] lo;
        send(op);
        lo = byte_out;
        send(8'hA5);
        check(req, {byte_out, lo}, exp);
        send(8'h5A);
        check("R9 idle after 16-bit read", {8'h00, byte_out}, 16'h0000);
    endtask

    task automatic write16(input logic [7:0] op, input logic [15:0] v);
        send(op);
        send(v[7:0]);
        send(v[15:8]);
    endtask

    task automatic read_bank(input string tag);
        read8(8'h01, model[1][7:0], {tag, " R6 control"});
        read16(8'h03, model[3], {tag, " R4 address"});
        read16(8'h04, model[4], {tag, " R4 data"});
        for (int i = 0; i < 6; i++)
            read16(8'h05 + 8'(i), model[5+i], {tag, " R7 breakpoint"});
    endtask

    function automatic bit defined_op(input logic [7:0] op);
        return (op >= 8'h01 && op <= 8'h0A) || op == 8'h11 ||
               (op >= 8'h13 && op <= 8'h1A) || op == 8'h1F;
    endfunction

    initial begin
        do_reset();
        check("R1 byte_out after reset", {8'h00, byte_out}, 16'h0000);
        check("R1 halt_req after reset", {15'h0, halt_req}, 16'h0000);
        read8(8'h02, 8'h00, "R3 flags after reset");
        read_bank("R1 reset");

        // two write passes with arithmetic patterns
        for (int pass = 0; pass < 2; pass++) begin
            logic [15:0] v;
            v = 16'(16'h00F1 * (pass + 3)) ^ 16'h5A00;
            send(8'h11); send(v[7:0]); model[1] = {8'h00, v[7:0]};
            for (int r = 3; r <= 10; r++) begin
                v = 16'(16'h1357 * (r + 7 * pass)) ^ 16'(r << 12);
                write16(8'h10 + 8'(r), v);
                model[r] = v;
            end
            read_bank("R5 pass");
        end

        // independence of breakpoints
        for (int i = 0; i < 6; i++) begin
            write16(8'h15 + 8'(i), 16'hC000 | 16'(i));
            model[5+i] = 16'hC000 | 16'(i);
            read_bank("R7 single bp write");
        end

        // sweep every undefined opcode
        for (int op = 0; op < 256; op++) begin
            if (!defined_op(8'(op))) begin
                send(8'(op));
                check("R2 undefined opcode byte_out", {8'h00, byte_out}, 16'h0000);
            end
        end
        check("R2 no halt from undefined", {15'h0, halt_req}, 16'h0000);
        read_bank("R2 after sweep");
        read8(8'h02, 8'h00, "R2 flags untouched by 0x12");

        // halt handshake
        send(8'h1F);
        check("R8 halt_req raised", {15'h0, halt_req}, 16'h0001);
        repeat (5) @(negedge clk);
        check("R8 halt_req held", {15'h0, halt_req}, 16'h0001);
        read8(8'h02, 8'h02, "R8 flags pending");
        @(negedge clk); cpu_halted = 1'b1;
        @(negedge clk); cpu_halted = 1'b0;
        check("R8 halt_req dropped", {15'h0, halt_req}, 16'h0000);
        read8(8'h02, 8'h01, "R8 flags debug mode");

        // reset mid-operation
        send(8'h13); send(8'h77);
        do_reset();
        check("R1 byte_out after reset", {8'h00, byte_out}, 16'h0000);
        read8(8'h02, 8'h00, "R1 flags cleared");
        read_bank("R1 second reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule